// File: doc/BRIEF.md
# PCI bus parity generator/checker

This block computes and checks the even parity bit of a 32-bit multiplexed address/data bus with four command/byte-enable lanes. The bus rule is that the parity line always trails the values it covers by one clock. The block keeps a registered copy of the parity of whatever was on AD and CBE at each clock edge. That single copy serves two purposes. When this agent drove AD and CBE, the copy is driven onto the parity line during the following clock. When another agent drove them, the copy is compared with the parity line sampled at the following edge.

The surrounding bus interface tells the block three things. `ad_oe` says whether this agent drives AD/CBE in the current clock, which covers the initiator address phase, the data source on a write or read, and bus parking. `rx_en` says whether this agent takes part in the current transaction. The framing and handshake lines come in as sampled bus values. The block drives the parity line with its own output enable. That enable is a one-clock-late copy of `ad_oe`, so the parity line is released one cycle after AD. The block also raises single-cycle address and data parity error pulses.

Top module: `pci_par_unit`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `par_o`, `par_oe`, `addr_perr` and `data_perr` are all 0 from the following clock onward, whatever the other inputs do.
- R2: After each rising edge, `par_o` equals the XOR of all bits of `ad_i` and `cbe_i` sampled at that edge. The 37 bits AD, CBE and PAR together therefore hold an even number of ones.
- R3: After each rising edge, `par_oe` equals the `ad_oe` value sampled at that edge, so the parity enable falls exactly one clock after `ad_oe` falls.
- R4: An address phase is an edge at which `frame_n` is sampled 0 and was sampled 1 at the previous edge; after reset the previous value counts as 1. If `ad_oe` was 0 at that edge and `par_i` sampled at the next edge differs from the XOR of the address-phase AD and CBE, `addr_perr` is 1 for the one clock after that next edge.
- R5: An address phase driven by this agent (`ad_oe` = 1 at that edge) never raises `addr_perr`, whatever `par_i` is at the next edge.
- R6: A data transfer is an edge with both `irdy_n` and `trdy_n` sampled 0. If such a transfer has `rx_en` = 1 and `ad_oe` = 0, and `par_i` at the next edge mismatches the XOR of that transfer's AD and CBE, `data_perr` is 1 for the one clock after that next edge.
- R7: An edge with `irdy_n` or `trdy_n` sampled 1 (a wait state) never leads to `data_perr`, even when the following `par_i` is wrong.
- R8: A transfer with `ad_oe` = 1 (this agent is the data source) or with `rx_en` = 0 never leads to `data_perr`.
- R9: Each error pulse lasts one clock per failing phase. A correct phase that follows returns the flag to 0, and back-to-back failing transfers keep `data_perr` high for one clock each.
- R10: While the bus is parked on this agent (`frame_n` = 1, `ad_oe` = 1), `par_o` and `par_oe` follow the parked AD/CBE values one clock later, as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_i | input | 32 | Sampled address/data bus |
| cbe_i | input | 4 | Sampled command/byte-enable lanes |
| par_i | input | 1 | Sampled bus parity line |
| frame_n | input | 1 | Sampled frame line, active low |
| irdy_n | input | 1 | Sampled initiator-ready line, active low |
| trdy_n | input | 1 | Sampled target-ready line, active low |
| ad_oe | input | 1 | This agent drives AD/CBE in this clock |
| rx_en | input | 1 | This agent takes part in the current transaction |
| par_o | output | 1 | Generated parity bit for the bus |
| par_oe | output | 1 | Parity output enable |
| addr_perr | output | 1 | One-clock address parity error pulse |
| data_perr | output | 1 | One-clock data parity error pulse |

## Verification
The assertions assume that every input carries a known level at each edge once reset is released. They also assume that `frame_n` behaves as a real bus frame line, so two address phases never fall on consecutive edges. The bench drives every input at the falling clock edge with defined values. It returns `frame_n` high between transactions and holds reset for several cycles before the first bus activity. Within those limits it deliberately places wrong parity after received and self-driven phases, after wait states and after non-participating transfers.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    localparam int unsigned AD_W_DEF   = 32;
    localparam int unsigned BE_W_DEF   = 4;
    localparam int unsigned LANE_W_DEF = 8;

    // Checks armed at one edge, resolved against PAR at the next edge
    typedef struct packed {
        logic addr_chk;
        logic data_chk;
    } chk_req_t;

    // Error pulses presented at the ports
    typedef struct packed {
        logic addr_err;
        logic data_err;
    } perr_t;

    function automatic logic is_addr_phase(input logic frame_now_n, input logic frame_prev_n);
        return !frame_now_n && frame_prev_n;
    endfunction

    function automatic logic is_xfer(input logic irdy_l, input logic trdy_l);
        return !irdy_l && !trdy_l;
    endfunction

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
    parameter int unsigned W      = 36,
    parameter int unsigned LANE_W = 8
) (
    input  logic [W-1:0] data,
    output logic         par
);
    localparam int unsigned NLANES = (W + LANE_W - 1) / LANE_W;
    localparam int unsigned PAD_W  = NLANES * LANE_W;

    logic [PAD_W-1:0]  padded;
    logic [NLANES-1:0] lane_par;

    generate
        if (PAD_W > W) begin : g_pad
            assign padded = {{(PAD_W - W){1'b0}}, data};
        end else begin : g_nopad
            assign padded = data;
        end
        for (genvar g = 0; g < NLANES; g++) begin : g_lane
            assign lane_par[g] = ^padded[g*LANE_W +: LANE_W];
        end
    endgenerate

    assign par = ^lane_par;

endmodule

// File: rtl/pci_par_phase.sv
module pci_par_phase
    import pci_par_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_n,
    input  logic     irdy_n,
    input  logic     trdy_n,
    input  logic     ad_oe,
    input  logic     rx_en,
    output chk_req_t req_q
);
    logic frame_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_prev_q <= 1'b1;
            req_q        <= '0;
        end else begin
            frame_prev_q   <= frame_n;
            req_q.addr_chk <= is_addr_phase(frame_n, frame_prev_q) && !ad_oe;
            req_q.data_chk <= is_xfer(irdy_n, trdy_n) && rx_en && !ad_oe;
        end
    end

endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
    import pci_par_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  chk_req_t req,
    input  logic     par_exp,
    input  logic     par_i,
    output perr_t    err_q
);
    logic mismatch;

    assign mismatch = par_i ^ par_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q.addr_err <= req.addr_chk && mismatch;
            err_q.data_err <= req.data_chk && mismatch;
        end
    end

endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
    import pci_par_pkg::*;
#(
    parameter int unsigned AD_W   = AD_W_DEF,
    parameter int unsigned BE_W   = BE_W_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_i,
    input  logic            par_i,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic            trdy_n,
    input  logic            ad_oe,
    input  logic            rx_en,
    output logic            par_o,
    output logic            par_oe,
    output logic            addr_perr,
    output logic            data_perr
);
    localparam int unsigned COV_W = AD_W + BE_W;

    logic [COV_W-1:0] covered;
    logic             par_now;
    logic             par_q;
    logic             oe_q;
    chk_req_t         req_q;
    perr_t            err_q;

    assign covered = {cbe_i, ad_i};

    pci_par_tree #(.W(COV_W), .LANE_W(LANE_W)) u_tree (
        .data (covered),
        .par  (par_now)
    );

    // One-clock pipeline: the same bit is driven out or used as the expectation
    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            par_q <= par_now;
            oe_q  <= ad_oe;
        end
    end

    pci_par_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .trdy_n  (trdy_n),
        .ad_oe   (ad_oe),
        .rx_en   (rx_en),
        .req_q   (req_q)
    );

    pci_par_check u_check (
        .clk     (clk),
        .rst     (rst),
        .req     (req_q),
        .par_exp (par_q),
        .par_i   (par_i),
        .err_q   (err_q)
    );

    assign par_o     = par_q;
    assign par_oe    = oe_q;
    assign addr_perr = err_q.addr_err;
    assign data_perr = err_q.data_err;

endmodule

// File: rtl/pci_par_unit_chk.sv
module pci_par_unit_chk #(
    parameter int unsigned AD_W = 32,
    parameter int unsigned BE_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [AD_W-1:0] ad_i,
    input logic [BE_W-1:0] cbe_i,
    input logic            frame_n,
    input logic            irdy_n,
    input logic            trdy_n,
    input logic            ad_oe,
    input logic            rx_en,
    input logic            par_o,
    input logic            par_oe,
    input logic            addr_perr,
    input logic            data_perr
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!par_o && !par_oe && !addr_perr && !data_perr));

    a_r2_par_even: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (par_o == ^{$past(cbe_i), $past(ad_i)}));

    a_r3_oe_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (par_oe == $past(ad_oe)));

    a_r5_own_addr_quiet: assert property (@(posedge clk) disable iff (rst)
        (!frame_n && ad_oe) |=> ##1 !addr_perr);

    a_r7_wait_quiet: assert property (@(posedge clk) disable iff (rst)
        (irdy_n || trdy_n) |=> ##1 !data_perr);

    a_r8_source_quiet: assert property (@(posedge clk) disable iff (rst)
        (ad_oe || !rx_en) |=> ##1 !data_perr);

    a_r9_addr_pulse: assert property (@(posedge clk) disable iff (rst)
        addr_perr |=> !addr_perr);

endmodule

bind pci_par_unit pci_par_unit_chk #(.AD_W(AD_W), .BE_W(BE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ad_i      (ad_i),
    .cbe_i     (cbe_i),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .trdy_n    (trdy_n),
    .ad_oe     (ad_oe),
    .rx_en     (rx_en),
    .par_o     (par_o),
    .par_oe    (par_oe),
    .addr_perr (addr_perr),
    .data_perr (data_perr)
);

// File: tb/test_pci_par_unit.sv
module test_pci_par_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        par_i = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic        ad_oe = 1'b0;
    logic        rx_en = 1'b0;
    logic        par_o, par_oe, addr_perr, data_perr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  par;
        logic  oe;
        logic  aerr;
        logic  derr;
        string tag;
    } exp_t;

    exp_t q[$];

    // Reference state built from the requirements
    logic m_par   = 1'b0;
    logic m_achk  = 1'b0;
    logic m_dchk  = 1'b0;
    logic m_fprev = 1'b1;

    always #5 clk = ~clk;

    pci_par_unit i_pci_par_unit (
        .clk       (clk),
        .rst       (rst),
        .ad_i      (ad_i),
        .cbe_i     (cbe_i),
        .par_i     (par_i),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .trdy_n    (trdy_n),
        .ad_oe     (ad_oe),
        .rx_en     (rx_en),
        .par_o     (par_o),
        .par_oe    (par_oe),
        .addr_perr (addr_perr),
        .data_perr (data_perr)
    );

    function automatic logic ep(input logic [31:0] a, input logic [3:0] c);
        return ^{c, a};
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, expv);
        end
    endtask

    // Driver: applies one bus clock of stimulus and queues the expected outputs
    task automatic step(input logic [31:0] a, input logic [3:0] c, input logic p,
                        input logic fr, input logic ir, input logic tr,
                        input logic oe, input logic rx, input string tag);
        exp_t e;
        @(negedge clk);
        ad_i = a; cbe_i = c; par_i = p; frame_n = fr;
        irdy_n = ir; trdy_n = tr; ad_oe = oe; rx_en = rx;
        e.par  = ep(a, c);
        e.oe   = oe;
        e.aerr = m_achk && (p != m_par);
        e.derr = m_dchk && (p != m_par);
        e.tag  = tag;
        q.push_back(e);
        m_par   = ep(a, c);
        m_achk  = !fr && m_fprev && !oe;
        m_dchk  = !ir && !tr && rx && !oe;
        m_fprev = fr;
    endtask

    // Monitor: compares after each edge, away from it
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk("R2", {e.tag, " par_o"}, par_o, e.par);
                chk("R3", {e.tag, " par_oe"}, par_oe, e.oe);
                chk(e.tag, "addr_perr", addr_perr, e.aerr);
                chk(e.tag, "data_perr", data_perr, e.derr);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        // R1: reset with activity on the inputs
        ad_oe = 1'b1; ad_i = 32'h0000_0001; par_i = 1'b1;
        frame_n = 1'b0; irdy_n = 1'b0; trdy_n = 1'b0; rx_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "par_o", par_o, 1'b0);
        chk("R1", "par_oe", par_oe, 1'b0);
        chk("R1", "addr_perr", addr_perr, 1'b0);
        chk("R1", "data_perr", data_perr, 1'b0);
        rst = 1'b0;
        frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; ad_oe = 1'b0; rx_en = 1'b0;

        // Idle, nobody driving
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R3");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R3");

        // R10: parked bus, several patterns; PAR follows one clock later
        step(32'hFFFF_FFFF, 4'hF, 1'b0, 1, 1, 1, 1, 0, "R10");
        step(32'h0000_0001, 4'h0, 1'b0, 1, 1, 1, 1, 0, "R10");
        step(32'hA5A5_5A5A, 4'h7, 1'b0, 1, 1, 1, 1, 0, "R10");
        step(32'h8000_0000, 4'h8, 1'b0, 1, 1, 1, 1, 0, "R10");
        // R3: release AD; enable drops a clock later
        step(32'h1234_5678, 4'h3, 1'b0, 1, 1, 1, 0, 0, "R3");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R3");

        // R4: address phase from another master, correct parity
        a = 32'h4000_0010;
        step(a, 4'h6, 1'b0, 0, 1, 1, 0, 0, "R4");
        step(32'h0, 4'h0, ep(a, 4'h6), 0, 0, 1, 0, 0, "R4");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R4");
        // R4: address phase with wrong parity
        a = 32'h4000_0020;
        step(a, 4'h7, 1'b0, 0, 1, 1, 0, 0, "R4");
        step(32'h0, 4'h0, ~ep(a, 4'h7), 0, 1, 1, 0, 0, "R4");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R9");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R9");

        // R5: own address phase, wrong PAR seen on the line
        a = 32'h0000_0F00;
        step(a, 4'h6, 1'b0, 0, 1, 1, 1, 1, "R5");
        step(32'h0, 4'h0, ~ep(a, 4'h6), 0, 1, 1, 0, 1, "R5");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R5");

        // R6/R9: received write data, back-to-back bad transfers then a good one
        step(32'h1111_0000, 4'h7, 1'b0, 0, 1, 1, 0, 1, "R6");
        step(32'hDEAD_BEEF, 4'h0, ~ep(32'h1111_0000, 4'h7), 0, 0, 0, 0, 1, "R6");
        step(32'hCAFE_F00D, 4'h3, ~ep(32'hDEAD_BEEF, 4'h0), 0, 0, 0, 0, 1, "R6");
        step(32'h0102_0304, 4'h0, ~ep(32'hCAFE_F00D, 4'h3), 1, 0, 0, 0, 1, "R9");
        step(32'h0, 4'h0, ep(32'h0102_0304, 4'h0), 1, 1, 1, 0, 0, "R9");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R9");

        // R7: wait states with wrong parity afterwards
        step(32'h2222_0000, 4'h6, 1'b0, 0, 1, 1, 0, 1, "R7");
        step(32'h0000_00FF, 4'h0, 1'b0, 0, 0, 1, 0, 1, "R7");
        step(32'h0000_00FE, 4'h0, ~ep(32'h0000_00FF, 4'h0), 0, 1, 0, 0, 1, "R7");
        step(32'h0, 4'h0, ~ep(32'h0000_00FE, 4'h0), 1, 1, 1, 0, 1, "R7");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R7");

        // R8: transfers where this agent is the source or not involved
        step(32'h3333_0000, 4'h7, 1'b0, 0, 1, 1, 1, 1, "R8");
        step(32'h7777_7777, 4'h0, 1'b0, 0, 0, 0, 1, 1, "R8");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 1, "R8");
        step(32'h4444_0000, 4'h7, ep(32'h0, 4'h0), 0, 1, 1, 0, 0, "R8");
        step(32'h0000_1234, 4'h0, ep(32'h4444_0000, 4'h7), 0, 0, 0, 0, 0, "R8");
        step(32'h0, 4'h0, ~ep(32'h0000_1234, 4'h0), 1, 1, 1, 0, 0, "R8");
        step(32'h0, 4'h0, 1'b0, 1, 1, 1, 0, 0, "R8");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule